// File: doc/BRIEF.md
# Two-Stage Interpolating Interval Combiner

This block measures the time between an asynchronous start event and an asynchronous stop event. It combines a coarse count of whole reference-clock periods with two fine interpolator codes. Each fine code gives, in fine bins, how far its event lay before the clock edge that caught it. One fine bin is the clock period divided by `PHASES`. The result, in fine bins, is the coarse count scaled by `PHASES`, plus the start code, minus the stop code. The interpolators that produce the codes sit outside this block. Their codes arrive on plain input buses and must be held steady until the event they belong to is accepted.

Both event lines pass through a synchronizer and a rising-edge detector. A control state machine has three states. `ST_IDLE` waits for a start. `ST_RUN` counts cycles until a stop. `ST_EMIT` presents the result for exactly one cycle. There are three transitions:
- arm: `ST_IDLE` to `ST_RUN`, on an accepted start edge;
- finish: `ST_RUN` to `ST_EMIT`, on an accepted stop edge;
- release: `ST_EMIT` to `ST_IDLE`, always after one cycle.

The result register is wide enough for the largest saturated count. It also carries a leading bit that is always zero, so the word can be read as signed without changing its value.

Top module: `tdc_interval_combiner`

## Requirements
- R1: After reset, `interval_vld_o` is 0 and `interval_o` is 0.
- R2: The coarse count C equals the number of clock periods between the first rising clock edge that samples `start_evt_i` high and the first rising clock edge that samples `stop_evt_i` high. C is therefore at least 1 for an accepted stop.
- R3: The result is C × `PHASES` + S − E. S is the start code and E is the stop code, both in the range 0 to `PHASES`−1.
- R4: The start code is captured in the cycle the start edge is accepted, and the stop code in the cycle the stop edge is accepted. Later changes on either code bus do not alter the result.
- R5: `interval_vld_o` is high for exactly one cycle. That cycle is the third clock cycle after the first edge that samples `stop_evt_i` high.
- R6: A stop edge while idle is ignored: no result is emitted.
- R7: A start edge while a measurement is running is ignored. The result still refers to the first start.
- R8: A start edge that arrives in the cycle the result is shown is ignored. No measurement begins, and a later stop gives no result.
- R9: The coarse count saturates at 2^`COARSE_W`−1 and does not wrap.
- R10: The top bit of `interval_o` is always 0 when valid is high. The result is never negative, and it never overflows.
- R11: Each accepted start clears the coarse count, so each result is independent of the measurement before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt_i | input | 1 | Asynchronous start event, active high |
| stop_evt_i | input | 1 | Asynchronous stop event, active high |
| start_code_i | input | FINE_W | Fine residue of the start event, in bins |
| stop_code_i | input | FINE_W | Fine residue of the stop event, in bins |
| interval_o | output | OUT_W | Measured interval, in fine bins |
| interval_vld_o | output | 1 | One-cycle strobe marking a new interval |

## Verification
Both events take two synchronizer cycles and one edge-detect cycle before the state machine acts on them. The start code is therefore latched at the third edge after start is driven, and the valid strobe appears in the third cycle after stop is driven. The bench drives every input on falling edges and counts falling edges from each stimulus. It expects valid at exactly step D+3 of a measurement whose stop follows its start by D cycles, and it flags a strobe on any other step. Ignore cases are judged at the ports: after the ignored event the bench drives a fresh stop and watches for ten cycles that no strobe appears.

// File: rtl/tdc_comb_pkg.sv
package tdc_comb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_EMIT = 2'd2
    } comb_state_e;

endpackage

// File: rtl/tdc_edge_sync.sv
module tdc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    output logic rise_o
);

    // pipe_q[STAGES-1] is the synchronized level; pipe_q[STAGES] is its previous value
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], evt_i};
        end
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

endmodule

// File: rtl/tdc_coarse_ctr.sv
module tdc_coarse_ctr #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          adv_i,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] CNT_TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clear_i) begin
            cnt_o <= CW'(1);
        end else if (adv_i && (cnt_o != CNT_TOP)) begin
            cnt_o <= cnt_o + CW'(1);
        end
    end

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clear_i && cnt_o == CNT_TOP) |=> (cnt_o == CNT_TOP));

    // R11
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_o == CW'(1)));

endmodule

// File: rtl/tdc_interval_arith.sv
module tdc_interval_arith #(
    parameter int PHASES = 16,
    parameter int FW     = 4,
    parameter int CW     = 12,
    parameter int OW     = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_ld_i,
    input  logic [FW-1:0] start_code_i,
    input  logic          stop_ld_i,
    input  logic [FW-1:0] stop_code_i,
    input  logic [CW-1:0] coarse_i,
    output logic [OW-1:0] interval_o
);

    logic [FW-1:0] start_res_q;
    logic [OW-1:0] scaled;
    logic [OW-1:0] total;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_res_q <= '0;
        end else if (start_ld_i) begin
            start_res_q <= start_code_i;
        end
    end

    always_comb begin
        scaled = OW'(coarse_i) * OW'(PHASES);
        total  = scaled + OW'(start_res_q) - OW'(stop_code_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            interval_o <= '0;
        end else if (stop_ld_i) begin
            interval_o <= total;
        end
    end

    // R10
    sign_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ld_i |=> !interval_o[OW-1]);

    // R3
    interval_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ld_i && coarse_i != '0) |=> (interval_o != '0));

endmodule

// File: rtl/tdc_interval_combiner.sv
module tdc_interval_combiner
    import tdc_comb_pkg::*;
#(
    parameter int  PHASES      = 16,
    parameter int  COARSE_W    = 12,
    parameter int  SYNC_STAGES = 2,
    localparam int FINE_W      = (PHASES > 1) ? $clog2(PHASES) : 1,
    localparam int OUT_W       = COARSE_W + FINE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt_i,
    input  logic              stop_evt_i,
    input  logic [FINE_W-1:0] start_code_i,
    input  logic [FINE_W-1:0] stop_code_i,
    output logic [OUT_W-1:0]  interval_o,
    output logic              interval_vld_o
);

    comb_state_e         state_q;
    comb_state_e         state_d;
    logic                start_rise;
    logic                stop_rise;
    logic                arm;
    logic                finish;
    logic                cnt_adv;
    logic [COARSE_W-1:0] coarse_cnt;

    tdc_edge_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (start_evt_i),
        .rise_o (start_rise)
    );

    tdc_edge_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (stop_evt_i),
        .rise_o (stop_rise)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_rise) state_d = ST_RUN;
            ST_RUN:  if (stop_rise)  state_d = ST_EMIT;
            ST_EMIT: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        arm            = (state_q == ST_IDLE) && start_rise;
        finish         = (state_q == ST_RUN) && stop_rise;
        cnt_adv        = (state_q == ST_RUN) && !stop_rise;
        interval_vld_o = (state_q == ST_EMIT);
    end

    tdc_coarse_ctr #(.CW(COARSE_W)) u_coarse (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (arm),
        .adv_i   (cnt_adv),
        .cnt_o   (coarse_cnt)
    );

    tdc_interval_arith #(
        .PHASES (PHASES),
        .FW     (FINE_W),
        .CW     (COARSE_W),
        .OW     (OUT_W)
    ) u_arith (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_ld_i   (arm),
        .start_code_i (start_code_i),
        .stop_ld_i    (finish),
        .stop_code_i  (stop_code_i),
        .coarse_i     (coarse_cnt),
        .interval_o   (interval_o)
    );

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_rise) |=> (state_q == ST_IDLE));

    // R7
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !stop_rise) |=> (state_q == ST_RUN));

    // R5
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        interval_vld_o |=> !interval_vld_o);

    // R8
    emit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT) |=> (state_q == ST_IDLE));

endmodule

// File: tb/test_tdc_interval_combiner.sv
`timescale 1ns/1ps
module test_tdc_interval_combiner;

    localparam int PH   = 16;
    localparam int CW   = 12;
    localparam int FW   = 4;
    localparam int OW   = CW + FW + 1;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_evt = 1'b0;
    logic          stop_evt = 1'b0;
    logic [FW-1:0] start_code = '0;
    logic [FW-1:0] stop_code = '0;
    logic [OW-1:0] interval;
    logic          vld;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tdc_interval_combiner #(.PHASES(PH), .COARSE_W(CW)) i_tdc_interval_combiner (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_evt_i    (start_evt),
        .stop_evt_i     (stop_evt),
        .start_code_i   (start_code),
        .stop_code_i    (stop_code),
        .interval_o     (interval),
        .interval_vld_o (vld)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // one measurement: stop driven d cycles after start; optional extra start at step xs
    task automatic measure(input int d, input int fs, input int fe, input int xs, input string tag);
        int cap;
        longint exp;
        bit extra;
        cap = (d > CMAX) ? CMAX : d;
        exp = longint'(cap) * PH + fs - fe;
        extra = 1'b0;
        for (int k = 0; k <= d + 6; k++) begin
            @(negedge clk);
            start_evt = (k < 4) || (xs >= 0 && k >= xs && k < xs + 4);
            stop_evt  = (k >= d) && (k < d + 4);
            if (k == 0) start_code = FW'(fs);
            if (k == 3) start_code = FW'(~fs);   // R4: changed after capture
            if (k == d) stop_code = FW'(fe);
            if (k == d + 3) begin
                stop_code = FW'(~fe);            // R4: changed after capture
                chk(vld == 1'b1, {tag, " R5 vld"}, vld, 1);
                chk(interval == OW'(exp), {tag, " R3"}, interval, exp);
                chk(interval[OW-1] == 1'b0, {tag, " R10"}, interval[OW-1], 0);
            end else if (vld) begin
                extra = 1'b1;
            end
        end
        start_evt = 1'b0;
        stop_evt = 1'b0;
        chk(!extra, {tag, " R5 single"}, extra, 0);
        repeat (2) @(negedge clk);
    endtask

    // stop pulse that must yield no result
    task automatic quiet_stop(input string tag);
        bit seen;
        seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            stop_evt = (k < 4);
            if (vld) seen = 1'b1;
        end
        stop_evt = 1'b0;
        chk(!seen, tag, seen, 0);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(vld == 1'b0, "R1 vld", vld, 0);
        chk(interval == '0, "R1 interval", interval, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R4: near-exhaustive fine code pairs, varying coarse
        for (int fs = 0; fs < PH; fs++) begin
            for (int fe = 0; fe < PH; fe++) begin
                measure(1 + ((fs * PH + fe) % 23), fs, fe, -1, "sweep");
            end
        end

        // R2: coarse length sweep; R11 long then short measurements
        for (int d = 1; d <= 40; d++) measure(d, d % PH, (d * 7) % PH, -1, "R2 len");
        measure(300, 5, 9, -1, "R11 long");
        measure(2, 5, 9, -1, "R11 short");

        // R10 extremes: minimum and maximum results
        measure(1, 0, PH - 1, -1, "R10 min");

        // R9 saturation
        measure(CMAX + 5, PH - 1, 0, -1, "R9 sat");
        measure(3, 1, 2, -1, "R9 after");

        // R6 stop while idle
        quiet_stop("R6 idle stop");
        measure(7, 3, 4, -1, "R6 after");

        // R7 second start while running
        measure(14, 6, 2, 6, "R7 busy start");

        // R8 start landing in the emit cycle
        measure(9, 8, 1, 10, "R8 emit start");
        quiet_stop("R8 no rearm");
        measure(5, 2, 11, -1, "R8 after");

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule